// File: doc/BRIEF.md
# Trimmed Real-Time Clock Prescaler

This block keeps wall-clock seconds from a slow oscillator. A one-cycle enable, pulsed once per oscillator period (32.768 kHz in the usual setting), drives a prescaler. Each time the prescaler completes its period, a 32-bit seconds counter advances by one and a one-cycle `sec_tick` pulse is raised. The default period is 2^PRE_W ticks, which is 32768.

A crystal that runs slightly fast or slow can be corrected without touching the oscillator. Software programs a signed 8-bit trim value and a repeat interval of 1 to 256 seconds. Once in every interval, one second is stretched or shortened by the trim amount. All the other seconds keep the nominal length.

The configuration sits behind a plain register port: write enable, 2-bit address and 32-bit data for writes, plus a separate combinational read address. Lock bits protect the trim settings. Counting runs only while the enable bit is set.

Top module: `rtc_trim_core`

## Requirements
- R1: After reset the seconds value is 1, counting is disabled, and the trim register, the lock register and the control register all read 0. The register map is: address 0 holds the seconds value; address 1 holds the trim value in [7:0] and the interval code in [15:8]; address 2 holds the trim lock in bit 0 and the self lock in bit 1; address 3 holds the enable in bit 0. Unused bits read 0.
- R2: With a trim value of 0, each seconds increment takes exactly 2^PRE_W counted ticks.
- R3: The interval in seconds is the interval code plus one. After the seconds value is written, second number 0 and every second whose index is a multiple of the interval last 2^PRE_W minus the trim value read as two's complement. All other seconds last 2^PRE_W. For example, 0x01 gives one tick fewer and 0x7F gives 127 fewer.
- R4: A negative trim value lengthens the adjusted second. 0xFF adds one tick and 0x80 adds 128 ticks.
- R5: The prescaler and the seconds value change only on cycles where `osc_tick` is high and the enable bit is 1. Gaps in `osc_tick` do not change the tick count of a second. While disabled, the seconds value holds.
- R6: Writes to the seconds register or the trim register while the enable bit is 1 are ignored.
- R7: A write to the seconds register also clears the prescaler and restarts the interval sequence at second index 0.
- R8: While the trim lock (address 2, bit 0) is 1, writes to the trim register are ignored.
- R9: While the self lock (address 2, bit 1) is 1, writes to the lock register are ignored, so both lock bits hold until reset.
- R10: `sec_tick` is high exactly on the counted tick that completes a second. The seconds value is one higher on the following cycle and wraps from 0xFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DATA_W | Combinational read data |
| seconds | output | DATA_W | Current seconds value |
| sec_tick | output | 1 | Pulse on the tick that completes a second |

## Verification
The hardest case to reach is the adjusted second when it recurs inside long intervals. It has to be separated from the nominal seconds around it, and the sum of the periods has to be shown to shift by exactly the trim amount once per interval.

The bench sets a small prescaler width, so a full second takes about a thousand cycles. Each phase writes the seconds value, which restarts the interval sequence. A driver then queues the expected length of every second. A monitor counts the enabled ticks between `sec_tick` pulses and pops the queue to compare them. Across the phases the bench covers positive and negative extremes of the trim value, the longest interval code, gaps in `osc_tick`, and a restart from a partly filled prescaler.

// File: rtl/rtc_trim_pkg.sv
// Shared register selectors and lock layout for the trimmed RTC core.
package rtc_trim_pkg;
    localparam int ADDR_W = 2;
    localparam int TRIM_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        SEL_SECS = 2'd0,
        SEL_TRIM = 2'd1,
        SEL_LOCK = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic self_lock;
        logic trim_lock;
    } lock_t;
endpackage

// File: rtl/rtc_trim_regs.sv
// Configuration registers: enable, trim value, interval code and lock bits.
// It also produces the one-cycle load strobe for the seconds value.
// Assumes DATA_W >= 16 so that the interval code field fits in the data word.
module rtc_trim_regs
    import rtc_trim_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                run_en,
    output logic [TRIM_W-1:0]   trim_val,
    output logic [TRIM_W-1:0]   ival_code,
    output lock_t               locks,
    output logic                sec_load,
    output logic [DATA_W-1:0]   sec_wdata
);
    localparam int IVAL_LSB = TRIM_W;

    logic cfg_open;

    // Configuration writes are accepted only while counting is stopped.
    assign cfg_open  = !run_en;
    assign sec_load  = wr_en && (wr_addr == SEL_SECS) && cfg_open;
    assign sec_wdata = wr_data;

    // Register updates, each gated by its own write rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en    <= 1'b0;
            trim_val  <= '0;
            ival_code <= '0;
            locks     <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                SEL_TRIM: if (cfg_open && !locks.trim_lock) begin
                    trim_val  <= wr_data[TRIM_W-1:0];
                    ival_code <= wr_data[IVAL_LSB +: TRIM_W];
                end
                SEL_LOCK: if (!locks.self_lock) begin
                    locks.trim_lock <= wr_data[0];
                    locks.self_lock <= wr_data[1];
                end
                SEL_CTRL: run_en <= wr_data[0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rtc_trim_comp.sv
// Compensation unit. An interval countdown marks the one adjusted second in
// each interval. The unit outputs the terminal prescaler count for the
// current second. Assumes PRE_W >= 8 so that the period stays positive.
module rtc_trim_comp
    import rtc_trim_pkg::*;
#(
    parameter int PRE_W = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TRIM_W-1:0]  trim_val,
    input  logic [TRIM_W-1:0]  ival_code,
    input  logic               sec_step,
    input  logic               restart,
    output logic [PRE_W:0]     pre_last
);
    localparam int PW = PRE_W + 1;
    localparam logic [PW-1:0] NOMINAL = PW'(1) << PRE_W;

    logic [TRIM_W-1:0] ival_left;
    logic              adj_sec;
    logic [PW-1:0]     trim_ext;
    logic [PW-1:0]     period;

    assign adj_sec  = (ival_left == '0);
    assign trim_ext = {{(PW-TRIM_W){trim_val[TRIM_W-1]}}, trim_val};

    // Select the period: adjusted in the marked second, nominal otherwise.
    always_comb begin
        period   = adj_sec ? (NOMINAL - trim_ext) : NOMINAL;
        pre_last = period - PW'(1);
    end

    // Interval countdown. It reloads after the adjusted second and restarts at a seconds write.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            ival_left <= '0;
        end else if (sec_step) begin
            ival_left <= adj_sec ? ival_code : ival_left - 1'b1;
        end
    end
endmodule

// File: rtl/rtc_trim_count.sv
// Prescaler and seconds counter. The prescaler counts enabled oscillator
// ticks up to pre_last and then wraps, which advances the seconds value.
module rtc_trim_count #(
    parameter int PRE_W  = 15,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              osc_tick,
    input  logic [PRE_W:0]    pre_last,
    input  logic              sec_load,
    input  logic [DATA_W-1:0] sec_wdata,
    output logic [DATA_W-1:0] seconds,
    output logic              sec_step
);
    logic [PRE_W:0] pre_cnt;
    logic           counting;

    assign counting = run_en && osc_tick;
    assign sec_step = counting && (pre_cnt == pre_last);

    // Prescaler: clear on a seconds load, wrap at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || sec_load) begin
            pre_cnt <= '0;
        end else if (counting) begin
            pre_cnt <= sec_step ? '0 : pre_cnt + 1'b1;
        end
    end

    // Seconds value: loaded by software, advanced at each prescaler wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seconds <= DATA_W'(1);
        end else if (sec_load) begin
            seconds <= sec_wdata;
        end else if (sec_step) begin
            seconds <= seconds + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_trim_core.sv
// Top of the trimmed RTC. It joins the register file, the compensation unit
// and the counter, and multiplexes the read port.
// Assumes osc_tick is already synchronous to clk and lasts one cycle.
module rtc_trim_core
    import rtc_trim_pkg::*;
#(
    parameter int PRE_W  = 15,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] seconds,
    output logic              sec_tick
);
    logic              run_en;
    logic [TRIM_W-1:0] trim_val;
    logic [TRIM_W-1:0] ival_code;
    lock_t             locks;
    logic              sec_load;
    logic [DATA_W-1:0] sec_wdata;
    logic [PRE_W:0]    pre_last;

    rtc_trim_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .run_en    (run_en),
        .trim_val  (trim_val),
        .ival_code (ival_code),
        .locks     (locks),
        .sec_load  (sec_load),
        .sec_wdata (sec_wdata)
    );

    rtc_trim_comp #(.PRE_W(PRE_W)) u_comp (
        .clk       (clk),
        .rst_n     (rst_n),
        .trim_val  (trim_val),
        .ival_code (ival_code),
        .sec_step  (sec_tick),
        .restart   (sec_load),
        .pre_last  (pre_last)
    );

    rtc_trim_count #(.PRE_W(PRE_W), .DATA_W(DATA_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .osc_tick  (osc_tick),
        .pre_last  (pre_last),
        .sec_load  (sec_load),
        .sec_wdata (sec_wdata),
        .seconds   (seconds),
        .sec_step  (sec_tick)
    );

    // Read multiplexer; unused bits read as zero.
    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(rd_addr))
            SEL_SECS: rd_data = seconds;
            SEL_TRIM: rd_data[2*TRIM_W-1:0] = {ival_code, trim_val};
            SEL_LOCK: rd_data[1:0] = {locks.self_lock, locks.trim_lock};
            SEL_CTRL: rd_data[0] = run_en;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rtc_trim_chk.sv
// Property checker for rtc_trim_core, attached to it by bind.
module rtc_trim_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              osc_tick,
    input logic              sec_tick,
    input logic [DATA_W-1:0] seconds,
    input logic              run_en,
    input logic [7:0]        trim_val,
    input logic [7:0]        ival_code,
    input logic              trim_lock,
    input logic              self_lock,
    input logic              sec_load
);
    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> (run_en && osc_tick)); // R5
    AST_SEC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> (seconds == $past(seconds) + DATA_W'(1))); // R10
    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !sec_load) |=> $stable(seconds)); // R5
    AST_RUN_FREEZES_TRIM: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> ($stable(trim_val) && $stable(ival_code))); // R6
    AST_RUN_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |-> !sec_load); // R6
    AST_TRIM_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        trim_lock |=> ($stable(trim_val) && $stable(ival_code))); // R8
    AST_SELF_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        self_lock |=> (self_lock && $stable(trim_lock))); // R9
endmodule

bind rtc_trim_core rtc_trim_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_tick  (osc_tick),
    .sec_tick  (sec_tick),
    .seconds   (seconds),
    .run_en    (run_en),
    .trim_val  (trim_val),
    .ival_code (ival_code),
    .trim_lock (locks.trim_lock),
    .self_lock (locks.self_lock),
    .sec_load  (sec_load)
);

// File: tb/rtc_trim_core_bench.sv
// Scoreboard bench: phase tasks queue the expected length of each second,
// and a monitor compares the counted ticks at every sec_tick.
module rtc_trim_core_bench;
    localparam int PRE_W  = 10;
    localparam int DATA_W = 32;
    localparam int N0     = 1 << PRE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              osc_tick = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [1:0]        rd_addr = '0;
    wire  [DATA_W-1:0] rd_data;
    wire  [DATA_W-1:0] seconds;
    wire               sec_tick;

    int          total = 0;
    int          bad = 0;
    int          exp_q[$];
    int          pe;
    logic [31:0] exp_sec = 32'd1;
    bit          counting = 1'b0;
    bit          gap_mode = 1'b0;
    bit          tick_on = 1'b0;
    int          tcnt = 0;
    int          phase_sum = 0;
    string       cur_req = "R2";
    logic [31:0] rv;

    rtc_trim_core #(.PRE_W(PRE_W), .DATA_W(DATA_W)) u_rtc_trim_core (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .seconds(seconds), .sec_tick(sec_tick)
    );

    always #2 clk = ~clk;

    // Oscillator tick source, changed just after each rising edge.
    always @(posedge clk) begin
        #1 osc_tick = tick_on && (gap_mode ? ~osc_tick : 1'b1);
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: count enabled ticks and compare at each second boundary.
    always @(negedge clk) begin
        if (rst_n) begin
            if (counting && osc_tick) tcnt++;
            if (sec_tick) begin
                phase_sum += tcnt;
                if (exp_q.size() == 0) begin
                    chk({cur_req, " R10 unexpected tick"}, 32'd1, 32'd0);
                end else begin
                    pe = exp_q.pop_front();
                    chk({cur_req, " period"}, tcnt, pe);
                end
                chk("R10 seconds at tick", seconds, exp_sec);
                exp_sec = exp_sec + 1;
                tcnt = 0;
            end
        end
    end

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic set_run(bit on);
        wr(2'd3, {31'd0, on});
        counting = on;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic load_secs(logic [31:0] v);
        wr(2'd0, v);
        tcnt = 0;
        exp_sec = v;
    endtask

    // Driver: queue the expected length of each second in a phase.
    task automatic run_phase(string req, logic [31:0] start, logic [7:0] trim,
                             logic [7:0] code, int nsec);
        byte signed s;
        int ival;
        s = trim;
        ival = int'(code) + 1;
        load_secs(start);
        wr(2'd1, {16'd0, code, trim});
        cur_req = req;
        for (int k = 0; k < nsec; k++)
            exp_q.push_back((k % ival == 0) ? N0 - int'(s) : N0);
        phase_sum = 0;
        set_run(1'b1);
        while (exp_q.size() != 0) @(negedge clk);
        set_run(1'b0);
        if (nsec % ival == 0)
            chk({req, " interval sum"}, phase_sum,
                (nsec / ival) * ival * N0 - (nsec / ival) * int'(s));
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, rv); chk("R1 seconds", rv, 32'd1);
        rd(2'd1, rv); chk("R1 trim", rv, 32'd0);
        rd(2'd2, rv); chk("R1 lock", rv, 32'd0);
        rd(2'd3, rv); chk("R1 ctrl", rv, 32'd0);
        // R5 ticks while disabled do nothing
        tick_on = 1'b1;
        repeat (50) @(negedge clk);
        chk("R5 idle seconds", seconds, 32'd1);

        run_phase("R2", 32'd1, 8'h00, 8'd0, 3);
        run_phase("R3", 32'd100, 8'h7F, 8'd3, 8);
        run_phase("R4", 32'hFFFF_FFFE, 8'h80, 8'd1, 4);
        chk("R10 wrap", seconds, 32'd2);
        gap_mode = 1'b1;
        run_phase("R5", 32'd7, 8'hFF, 8'd0, 3);
        gap_mode = 1'b0;
        run_phase("R3", 32'd20, 8'h01, 8'd255, 2);

        // R6: configuration writes while running are ignored
        load_secs(32'd40);
        wr(2'd1, 32'd0);
        set_run(1'b1);
        repeat (300) @(negedge clk);
        wr(2'd0, 32'd777);
        wr(2'd1, 32'h0355);
        rd(2'd1, rv); chk("R6 trim kept", rv, 32'd0);
        chk("R6 seconds kept", seconds, 32'd40);
        set_run(1'b0);
        repeat (100) @(negedge clk);
        chk("R5 disabled hold", seconds, 32'd40);
        // R7: a seconds write clears the partly filled prescaler
        run_phase("R7", 32'd50, 8'h00, 8'd0, 1);

        // R8: trim lock
        wr(2'd2, 32'd1);
        wr(2'd1, 32'h0A0B);
        rd(2'd1, rv); chk("R8 trim locked", rv, 32'd0);
        wr(2'd2, 32'd0);
        rd(2'd2, rv); chk("R8 unlock", rv, 32'd0);
        wr(2'd1, 32'h0A0B);
        rd(2'd1, rv); chk("R8 trim open", rv, 32'h0A0B);
        // R9: self lock
        wr(2'd2, 32'd3);
        wr(2'd2, 32'd0);
        rd(2'd2, rv); chk("R9 self lock held", rv, 32'd3);
        wr(2'd1, 32'd0);
        rd(2'd1, rv); chk("R9 trim still locked", rv, 32'h0A0B);

        chk("R3 queue drained", exp_q.size(), 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule